// File: doc/BRIEF.md
# Manual-Mode Serial Flash Sequencer

This block runs one serial flash transaction at a time. Each transaction is a fixed series of optional phases: a command byte, a second command byte, an address, option bytes, dummy cycles and a data phase of up to four bytes. Each phase has its own enable and its own bus-width code, so one transaction can mix single-, dual- and quad-line phases. The configuration inputs are captured when a start request is accepted. The block then drives a serial clock, an active-low chip select and a four-line data bus with per-line output enables.

Longer payloads are built in software by chaining four-byte transfers. The keep-select control leaves chip select asserted after a transfer ends, so the next transfer continues the same flash transaction. A transfer-end flag tells software when the next transfer may be started. Up to four received bytes are returned left-aligned in a 32-bit word.

Top module: `sfs_seq`

## Requirements
- R1: Phases go out in this order: command, second command, address, option, dummy, data. A phase whose enable is clear is skipped. Chip select stays low while phases run.
- R2: A phase width code of 0, 1 or 2 uses 1, 2 or 4 lines. A 1-line phase drives sd_o[0] only and reads from sd_i[1]. A wider phase uses the low lines, with the most significant bits on the higher line. Every byte is sent MSB first.
- R3: Address enable 4'hF sends all 32 address bits. Any other nonzero value sends only address bits 23:0. Zero skips the address phase.
- R4: The option and data phases each take a 4-bit byte mask whose set bits run from bit 3 downward. The number of set bits N is the byte count, and the phase sends bits 31 down to 32-8N of its word.
- R5: When the dummy enable is set, the dummy phase lasts (dummy count field + 1) serial clocks, and all output enables are low for its whole length.
- R6: The data phase runs only when the data mask is nonzero and read or write is enabled. Without either, only the header phases run. When both are set, the phase is a read.
- R7: The done flag is low after reset. It clears when a start is accepted and is never high while the block is busy. A start request while busy is ignored, including any configuration change that comes with it.
- R8: With keep-select set, chip select stays low after the transfer ends, until a later transfer without keep-select completes.
- R9: With keep-select clear, chip select goes high at least one full serial clock period (2 system clocks) before done rises.
- R10: The serial clock is the system clock divided by 2. It idles low and rises every 2 system clocks during a transfer. Output data and enables change only when the serial clock falls.
- R11: Read bytes are returned in rdata_o with the first received byte in bits 31:24. Bytes that were not received read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, acted on only when idle |
| rd_en_i | input | 1 | Data phase is a read |
| wr_en_i | input | 1 | Data phase is a write |
| keep_cs_i | input | 1 | Hold chip select after the transfer ends |
| cmd_en_i | input | 1 | Command phase enable |
| cmd_w_i | input | 2 | Command width code |
| cmd_i | input | 8 | Command byte |
| ocmd_en_i | input | 1 | Second command enable |
| ocmd_w_i | input | 2 | Second command width code |
| ocmd_i | input | 8 | Second command byte |
| addr_en_i | input | 4 | Address enable (0, 7 or F) |
| addr_w_i | input | 2 | Address width code |
| addr_i | input | 32 | Address value |
| opt_en_i | input | 4 | Option byte mask |
| opt_w_i | input | 2 | Option width code |
| opt_i | input | 32 | Option bytes |
| dmy_en_i | input | 1 | Dummy phase enable |
| dmy_cyc_i | input | 5 | Dummy cycles minus one |
| data_en_i | input | 4 | Data byte mask |
| data_w_i | input | 2 | Data width code |
| wdata_i | input | 32 | Write data |
| sd_i | input | 4 | Serial data in |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| sd_o | output | 4 | Serial data out |
| sd_oe_o | output | 4 | Per-line output enable |
| rdata_o | output | 32 | Read data, left-aligned |
| done_o | output | 1 | Transfer-end flag |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions assume that width codes never exceed 2, that nonzero masks are contiguous from bit 3 downward, and that the address enable is 0, 7 or F. They also assume that software waits for done before issuing a start it expects to take effect. The bench builds every configuration from these legal values only, and it drives sd_i only while the serial clock is low. Every transfer it runs has at least one phase enabled, so busy always rises after an accepted start.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int WORD_W = 32;
  localparam int DMY_W  = 5;
  localparam int CNT_W  = 6;
  localparam int LINES  = 4;

  typedef enum logic [2:0] {
    SEG_CMD  = 3'd0,
    SEG_OCMD = 3'd1,
    SEG_ADDR = 3'd2,
    SEG_OPT  = 3'd3,
    SEG_DMY  = 3'd4,
    SEG_DATA = 3'd5,
    SEG_END  = 3'd6
  } seg_e;

  typedef struct packed {
    logic              cmd_en;
    logic [1:0]        cmd_w;
    logic [7:0]        cmd;
    logic              ocmd_en;
    logic [1:0]        ocmd_w;
    logic [7:0]        ocmd;
    logic [3:0]        addr_en;
    logic [1:0]        addr_w;
    logic [WORD_W-1:0] addr;
    logic [3:0]        opt_en;
    logic [1:0]        opt_w;
    logic [WORD_W-1:0] opt;
    logic              dmy_en;
    logic [DMY_W-1:0]  dmy_cyc;
    logic [3:0]        data_en;
    logic [1:0]        data_w;
    logic [WORD_W-1:0] wdata;
    logic              rd;
    logic              wr;
    logic              keep;
  } cfg_t;
endpackage

// File: rtl/sfs_phase_sel.sv
module sfs_phase_sel
  import sfs_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [2:0]        base_i,
  output seg_e              seg_o,
  output logic [WORD_W-1:0] pay_o,
  output logic [CNT_W-1:0]  cyc_o,
  output logic [1:0]        w_o
);
  logic [6:0] en;
  logic [2:0] nbytes;

  always_comb begin
    en    = '0;
    en[0] = cfg_i.cmd_en;
    en[1] = cfg_i.ocmd_en;
    en[2] = |cfg_i.addr_en;
    en[3] = |cfg_i.opt_en;
    en[4] = cfg_i.dmy_en;
    en[5] = (|cfg_i.data_en) && (cfg_i.rd || cfg_i.wr);
    en[6] = 1'b1;
  end

  // first enabled phase at or after base_i
  always_comb begin
    seg_o = SEG_END;
    for (int i = 6; i >= 0; i--) begin
      if (en[i] && (3'(i) >= base_i)) seg_o = seg_e'(3'(i));
    end
  end

  always_comb begin
    pay_o  = '0;
    nbytes = 3'd0;
    w_o    = 2'd0;
    case (seg_o)
      SEG_CMD:  begin pay_o = {cfg_i.cmd, 24'h0};  nbytes = 3'd1; w_o = cfg_i.cmd_w;  end
      SEG_OCMD: begin pay_o = {cfg_i.ocmd, 24'h0}; nbytes = 3'd1; w_o = cfg_i.ocmd_w; end
      SEG_ADDR: begin
        w_o = cfg_i.addr_w;
        if (cfg_i.addr_en == 4'hF) begin
          pay_o = cfg_i.addr; nbytes = 3'd4;
        end else begin
          pay_o = {cfg_i.addr[23:0], 8'h0}; nbytes = 3'd3;
        end
      end
      SEG_OPT:  begin pay_o = cfg_i.opt;   nbytes = 3'($countones(cfg_i.opt_en));  w_o = cfg_i.opt_w;  end
      SEG_DATA: begin pay_o = cfg_i.wdata; nbytes = 3'($countones(cfg_i.data_en)); w_o = cfg_i.data_w; end
      default: ;
    endcase
    if (seg_o == SEG_DMY) cyc_o = CNT_W'(cfg_i.dmy_cyc) + CNT_W'(1);
    else                  cyc_o = CNT_W'({nbytes, 3'b000} >> w_o);
  end
endmodule

// File: rtl/sfs_shift.sv
module sfs_shift
  import sfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] pay_i,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              clr_i,
  input  logic [1:0]        w_i,
  input  logic [LINES-1:0]  sd_i,
  output logic [LINES-1:0]  tx_o,
  output logic [WORD_W-1:0] rx_o
);
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i) tx_q <= pay_i;
      else if (shift_i) begin
        case (w_i)
          2'd0:    tx_q <= {tx_q[WORD_W-2:0], 1'b0};
          2'd1:    tx_q <= {tx_q[WORD_W-3:0], 2'b0};
          default: tx_q <= {tx_q[WORD_W-5:0], 4'b0};
        endcase
      end
      if (clr_i) rx_q <= '0;
      else if (cap_i) begin
        case (w_i)
          2'd0:    rx_q <= {rx_q[WORD_W-2:0], sd_i[1]};
          2'd1:    rx_q <= {rx_q[WORD_W-3:0], sd_i[1:0]};
          default: rx_q <= {rx_q[WORD_W-5:0], sd_i};
        endcase
      end
    end
  end

  always_comb begin
    case (w_i)
      2'd0:    tx_o = {3'b000, tx_q[WORD_W-1]};
      2'd1:    tx_o = {2'b00, tx_q[WORD_W-1:WORD_W-2]};
      default: tx_o = tx_q[WORD_W-1:WORD_W-4];
    endcase
  end

  assign rx_o = rx_q;
endmodule

// File: rtl/sfs_seq.sv
module sfs_seq
  import sfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              keep_cs_i,
  input  logic              cmd_en_i,
  input  logic [1:0]        cmd_w_i,
  input  logic [7:0]        cmd_i,
  input  logic              ocmd_en_i,
  input  logic [1:0]        ocmd_w_i,
  input  logic [7:0]        ocmd_i,
  input  logic [3:0]        addr_en_i,
  input  logic [1:0]        addr_w_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [3:0]        opt_en_i,
  input  logic [1:0]        opt_w_i,
  input  logic [WORD_W-1:0] opt_i,
  input  logic              dmy_en_i,
  input  logic [DMY_W-1:0]  dmy_cyc_i,
  input  logic [3:0]        data_en_i,
  input  logic [1:0]        data_w_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LINES-1:0]  sd_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic [LINES-1:0]  sd_o,
  output logic [LINES-1:0]  sd_oe_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} st_e;

  st_e               st_q;
  seg_e              seg_q, nseg;
  cfg_t              cfg_in, cfg_q, cfg_sel;
  logic [1:0]        w_q, nw;
  logic [CNT_W-1:0]  cnt_q, ncyc;
  logic [WORD_W-1:0] npay, rx_word, rdata_q;
  logic [LINES-1:0]  tx_bits, lane;
  logic [2:0]        base, data_nb;
  logic              sck_q, cs_nq, done_q, tail_q;
  logic              start_ok, rise, fall, seg_last, rx_seg, tx_seg, load, fin;

  always_comb begin
    cfg_in         = '0;
    cfg_in.cmd_en  = cmd_en_i;  cfg_in.cmd_w  = cmd_w_i;  cfg_in.cmd  = cmd_i;
    cfg_in.ocmd_en = ocmd_en_i; cfg_in.ocmd_w = ocmd_w_i; cfg_in.ocmd = ocmd_i;
    cfg_in.addr_en = addr_en_i; cfg_in.addr_w = addr_w_i; cfg_in.addr = addr_i;
    cfg_in.opt_en  = opt_en_i;  cfg_in.opt_w  = opt_w_i;  cfg_in.opt  = opt_i;
    cfg_in.dmy_en  = dmy_en_i;  cfg_in.dmy_cyc = dmy_cyc_i;
    cfg_in.data_en = data_en_i; cfg_in.data_w = data_w_i; cfg_in.wdata = wdata_i;
    cfg_in.rd      = rd_en_i;   cfg_in.wr     = wr_en_i;  cfg_in.keep = keep_cs_i;
  end

  assign cfg_sel = (st_q == ST_IDLE) ? cfg_in : cfg_q;
  assign base    = (st_q == ST_IDLE) ? 3'd0 : 3'(seg_q) + 3'd1;

  sfs_phase_sel u_sel (
    .cfg_i (cfg_sel),
    .base_i(base),
    .seg_o (nseg),
    .pay_o (npay),
    .cyc_o (ncyc),
    .w_o   (nw)
  );

  assign start_ok = start_i && (st_q == ST_IDLE);
  assign rise     = (st_q == ST_RUN) && !sck_q;
  assign fall     = (st_q == ST_RUN) && sck_q;
  assign seg_last = fall && (cnt_q == CNT_W'(1));
  assign rx_seg   = (seg_q == SEG_DATA) && cfg_q.rd;
  assign tx_seg   = (st_q == ST_RUN) && (seg_q != SEG_DMY) && !rx_seg;
  assign load     = (start_ok || seg_last) && (nseg != SEG_END);
  assign fin      = (start_ok || seg_last) && (nseg == SEG_END);
  assign data_nb  = 3'($countones(cfg_q.data_en));

  sfs_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .pay_i  (npay),
    .shift_i(fall),
    .cap_i  (rise && rx_seg),
    .clr_i  (start_ok),
    .w_i    (w_q),
    .sd_i   (sd_i),
    .tx_o   (tx_bits),
    .rx_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      seg_q   <= SEG_CMD;
      cfg_q   <= '0;
      w_q     <= 2'd0;
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      cs_nq   <= 1'b1;
      done_q  <= 1'b0;
      tail_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start_ok) begin
        cfg_q  <= cfg_in;
        done_q <= 1'b0;
      end
      if (load) begin
        seg_q <= nseg;
        w_q   <= nw;
        cnt_q <= ncyc;
      end
      case (st_q)
        ST_IDLE: if (load) begin
          st_q  <= ST_RUN;
          cs_nq <= 1'b0;
        end
        ST_RUN: begin
          sck_q <= !sck_q;
          if (fall && (cnt_q != CNT_W'(1))) cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_TAIL: begin
          tail_q <= 1'b1;
          if (tail_q) begin
            tail_q <= 1'b0;
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (seg_last && rx_seg) rdata_q <= rx_word << {3'd4 - data_nb, 3'b000};
      if (fin) begin
        if (cfg_sel.keep) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          st_q  <= ST_TAIL;
          cs_nq <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (w_q)
      2'd0:    lane = 4'b0001;
      2'd1:    lane = 4'b0011;
      default: lane = 4'b1111;
    endcase
  end

  assign sck_o   = sck_q;
  assign cs_no   = cs_nq;
  assign sd_oe_o = tx_seg ? lane : '0;
  assign sd_o    = tx_seg ? (tx_bits & lane) : '0;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;
  assign busy_o  = (st_q != ST_IDLE);

  // R10
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o);
  // R10
  sck_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);
  // R1
  cs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> !cs_no);
  // R7
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R8
  keep_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && cfg_q.keep) |-> !cs_no);
  // R9
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !cfg_q.keep) |-> (cs_no && $past(cs_no)));
endmodule

// File: tb/sfs_seq_bench.sv
module sfs_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, rd_en_i = 1'b0, wr_en_i = 1'b0, keep_cs_i = 1'b0;
  logic        cmd_en_i = 1'b0, ocmd_en_i = 1'b0, dmy_en_i = 1'b0;
  logic [1:0]  cmd_w_i = '0, ocmd_w_i = '0, addr_w_i = '0, opt_w_i = '0, data_w_i = '0;
  logic [7:0]  cmd_i = '0, ocmd_i = '0;
  logic [3:0]  addr_en_i = '0, opt_en_i = '0, data_en_i = '0;
  logic [31:0] addr_i = '0, opt_i = '0, wdata_i = '0;
  logic [4:0]  dmy_cyc_i = '0;
  logic [3:0]  sd_i = '0;
  logic        sck_o, cs_no, done_o, busy_o;
  logic [3:0]  sd_o, sd_oe_o;
  logic [31:0] rdata_o;

  always #10 clk = ~clk;

  sfs_seq u_sfs_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .keep_cs_i(keep_cs_i), .cmd_en_i(cmd_en_i), .cmd_w_i(cmd_w_i), .cmd_i(cmd_i),
    .ocmd_en_i(ocmd_en_i), .ocmd_w_i(ocmd_w_i), .ocmd_i(ocmd_i), .addr_en_i(addr_en_i),
    .addr_w_i(addr_w_i), .addr_i(addr_i), .opt_en_i(opt_en_i), .opt_w_i(opt_w_i),
    .opt_i(opt_i), .dmy_en_i(dmy_en_i), .dmy_cyc_i(dmy_cyc_i), .data_en_i(data_en_i),
    .data_w_i(data_w_i), .wdata_i(wdata_i), .sd_i(sd_i), .sck_o(sck_o), .cs_no(cs_no),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o), .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o)
  );

  int errors = 0, checks = 0;
  logic [3:0] exp_oe [0:255];
  logic [3:0] exp_val[0:255];
  logic [3:0] cap_oe [0:511];
  logic [3:0] cap_val[0:511];
  int n_exp = 0, n_cap = 0, base_idx = 0, viol = 0, samp = 0, last_rise = -1, cs_run = 0;
  int rd_h = 0, rd_n = 0, rd_l = 1;
  bit rd_act = 1'b0;
  logic [31:0] rb = '0, exp_rdata = '0;
  logic prev_sck = 1'b0;
  logic [3:0] prev_sd = '0, prev_oe = '0;

  function automatic logic [3:0] mask_of(input int n);
    return 4'((4'hF << (4 - n)) & 4'hF);
  endfunction

  function automatic logic [3:0] rd_chunk(input int k);
    logic [31:0] v;
    if (!rd_act || k < rd_h || k >= rd_h + rd_n) return 4'hF;
    v = (rb >> (32 - rd_l * (k - rd_h + 1))) & ((32'd1 << rd_l) - 32'd1);
    if (rd_l == 1) return {2'b00, v[0], 1'b0};
    return v[3:0];
  endfunction

  // serial-side monitor and read-data responder
  always @(negedge clk) begin
    if (busy_o && sck_o && !prev_sck) begin
      cap_oe[n_cap % 512]  = sd_oe_o;
      cap_val[n_cap % 512] = sd_o;
      if (last_rise >= 0 && samp - last_rise != 2) viol++;
      if (sd_o !== prev_sd || sd_oe_o !== prev_oe) viol++;
      last_rise = samp;
      n_cap++;
    end
    if (!busy_o) last_rise = -1;
    cs_run = cs_no ? cs_run + 1 : 0;
    if (!sck_o) sd_i = rd_chunk(n_cap - base_idx);
    prev_sck = sck_o; prev_sd = sd_o; prev_oe = sd_oe_o;
    samp++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push_tx(input logic [31:0] p, input int nb, input int w);
    int l = 1 << w;
    for (int i = 0; i < nb * 8 / l; i++) begin
      exp_oe[n_exp]  = 4'((1 << l) - 1);
      exp_val[n_exp] = 4'((p >> (32 - l * (i + 1))) & ((32'd1 << l) - 32'd1));
      n_exp++;
    end
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_oe[n_exp] = 4'h0; exp_val[n_exp] = 4'h0; n_exp++;
    end
  endtask

  task automatic clear_cfg();
    rd_en_i = 0; wr_en_i = 0; keep_cs_i = 0;
    cmd_en_i = 0; ocmd_en_i = 0; dmy_en_i = 0;
    addr_en_i = 0; opt_en_i = 0; data_en_i = 0;
    cmd_w_i = 0; ocmd_w_i = 0; addr_w_i = 0; opt_w_i = 0; data_w_i = 0;
    dmy_cyc_i = 0;
  endtask

  task automatic run_xfer(input string tag, input bit poke);
    int nb, mism, v0;
    logic [7:0] cmd_save;
    n_exp = 0; rd_act = 0;
    rb = $urandom;
    if (cmd_en_i)  push_tx({cmd_i, 24'h0}, 1, cmd_w_i);
    if (ocmd_en_i) push_tx({ocmd_i, 24'h0}, 1, ocmd_w_i);
    if (addr_en_i == 4'hF) push_tx(addr_i, 4, addr_w_i);
    else if (addr_en_i != 0) push_tx({addr_i[23:0], 8'h0}, 3, addr_w_i);
    if (opt_en_i != 0) push_tx(opt_i, $countones(opt_en_i), opt_w_i);
    if (dmy_en_i) push_idle(int'(dmy_cyc_i) + 1);
    nb = $countones(data_en_i);
    if (nb != 0 && rd_en_i) begin
      rd_l = 1 << data_w_i; rd_h = n_exp; rd_n = nb * 8 / rd_l;
      push_idle(rd_n);
      exp_rdata = rb & ~(32'hFFFF_FFFF >> (nb * 8));
      rd_act = 1;
    end else if (nb != 0 && wr_en_i) push_tx(wdata_i, nb, data_w_i);
    base_idx = n_cap; v0 = viol;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(!done_o && busy_o, "R7 done cleared and busy after start", {done_o, busy_o}, 2'b01);
    if (poke) begin
      cmd_save = cmd_i;
      repeat (5) @(negedge clk);
      cmd_i = ~cmd_i; start_i = 1;
      @(negedge clk) start_i = 0;
      chk(!done_o && busy_o, "R7 start while busy", {done_o, busy_o}, 2'b01);
      cmd_i = cmd_save;
    end
    while (!done_o) @(negedge clk);
    chk(n_cap - base_idx == n_exp, {tag, " serial clock count"}, n_cap - base_idx, n_exp);
    mism = 0;
    for (int i = 0; i < n_exp; i++) begin
      int j = (base_idx + i) % 512;
      if (cap_oe[j] !== exp_oe[i] || (exp_oe[i] != 0 && cap_val[j] !== exp_val[i])) mism++;
    end
    chk(mism == 0, {tag, " line contents"}, mism, 0);
    chk(viol == v0, "R10 clock period and fall-edge data", viol - v0, 0);
    if (keep_cs_i) chk(cs_no == 1'b0, "R8 select held at end", cs_no, 0);
    else chk(cs_no && cs_run >= 2, "R9 select released before done", cs_run, 2);
    if (rd_act) chk(rdata_o == exp_rdata, "R11 read data alignment", rdata_o, exp_rdata);
    rd_act = 0;
  endtask

  initial begin
    int idx = 0;
    clear_cfg();
    repeat (3) @(negedge clk);
    chk(cs_no && !sck_o && !done_o && !busy_o && sd_oe_o == 0, "R10 reset state",
        {cs_no, sck_o, done_o, busy_o, sd_oe_o}, 8'h80);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // sweep over width code, direction and data length
    for (int w = 0; w < 3; w++) begin
      for (int dir = 0; dir < 3; dir++) begin
        for (int nb = 1; nb <= 4; nb++) begin
          clear_cfg();
          cmd_en_i  = !(dir != 0 && idx % 5 == 4);
          cmd_w_i   = 2'(w); cmd_i = 8'(8'h30 + idx);
          ocmd_en_i = idx[0]; ocmd_w_i = 2'(w); ocmd_i = 8'(8'hC0 ^ idx);
          addr_en_i = (idx % 7 == 3) ? 4'h0 : (idx[1] ? 4'hF : 4'h7);
          addr_w_i  = 2'((w + idx) % 3); addr_i = $urandom;
          opt_en_i  = idx[2] ? 4'h0 : mask_of((idx >> 1) % 4 + 1);
          opt_w_i   = 2'((w + 1) % 3); opt_i = $urandom;
          dmy_en_i  = idx[0] ^ idx[1]; dmy_cyc_i = 5'(idx % 8);
          data_en_i = mask_of(nb); data_w_i = 2'(w); wdata_i = $urandom;
          rd_en_i   = (dir == 2); wr_en_i = (dir == 1);
          run_xfer("R1/R2", 1'b0);
          idx++;
        end
      end
    end

    // R3 address lengths
    for (int k = 0; k < 2; k++) begin
      clear_cfg();
      addr_en_i = k[0] ? 4'hF : 4'h7; addr_i = 32'hA5C3_1E77; addr_w_i = 2'(k);
      run_xfer("R3", 1'b0);
    end

    // R4 option masks
    for (int nb = 1; nb <= 4; nb++) begin
      clear_cfg();
      opt_en_i = mask_of(nb); opt_i = 32'h1234_5678 + 32'(nb); opt_w_i = 2'd1;
      run_xfer("R4", 1'b0);
    end

    // R5 dummy length extremes
    for (int k = 0; k < 2; k++) begin
      clear_cfg();
      cmd_en_i = 1; cmd_i = 8'h6B; dmy_en_i = 1; dmy_cyc_i = k[0] ? 5'd31 : 5'd0;
      run_xfer("R5", 1'b0);
    end

    // R6 mask set but no direction, then both directions
    clear_cfg();
    cmd_en_i = 1; cmd_i = 8'h9F; data_en_i = 4'hF; wdata_i = 32'hDEAD_BEEF;
    run_xfer("R6 no direction", 1'b0);
    clear_cfg();
    cmd_en_i = 1; cmd_i = 8'h05; data_en_i = mask_of(2); data_w_i = 2'd2;
    rd_en_i = 1; wr_en_i = 1;
    run_xfer("R6 read wins", 1'b0);

    // R7 ignored start during a transfer
    clear_cfg();
    cmd_en_i = 1; cmd_i = 8'h3C; addr_en_i = 4'hF; addr_i = 32'h0BAD_F00D;
    run_xfer("R7 busy start", 1'b1);

    // R8 chained transfers with select held
    clear_cfg();
    cmd_en_i = 1; cmd_i = 8'h02; addr_en_i = 4'h7; addr_i = 32'h0000_1000;
    data_en_i = 4'hF; wr_en_i = 1; wdata_i = 32'h0102_0304; keep_cs_i = 1;
    run_xfer("R8 first", 1'b0);
    repeat (6) @(negedge clk);
    chk(cs_no == 1'b0 && !sck_o, "R8 select idle between chained transfers", {cs_no, sck_o}, 0);
    clear_cfg();
    data_en_i = mask_of(3); wr_en_i = 1; wdata_i = 32'hAABB_CC00; data_w_i = 2'd2;
    run_xfer("R8 last", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule